// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector (non-overlapping, Mealy output)

This block watches a one-bit serial stream, sampling it on each rising clock edge, and raises a detect flag when the last three bits seen form the pattern 1, 0, 1. The flag is a Mealy output. It is decoded from the held state and the bit currently on the input, so it is valid during the same cycle in which the final 1 is presented, before the edge that consumes it.

The state is held in two flip-flops. After a match the machine goes back to idle, so bits from a completed match are never reused in a later one. A stream such as 1,0,1,0,1 flags once, on the third bit. A second flag needs a fresh 1,0,1 after the match. The serial input is assumed to change only between active edges. The reset is synchronous and active high.

Top module: `pat101_detect`

## Requirements
- R1: A rising edge with `rst` high puts the detector in idle. While `rst` is high with `din` at 0, `hit` is 0. After reset is released, a 1 on `din` does not flag, even if 1,0 was seen just before the reset.
- R2: In idle, a 0 keeps the detector in idle and a 1 moves it to the seen-1 state. `hit` is 0 in idle whatever the value of `din`.
- R3: In seen-1, a further 1 keeps the detector in seen-1, so the stream 1,1,0,1 flags on its fourth bit.
- R4: `hit` is 1 only when the detector holds seen-1-then-0 and `din` is 1. It is high in the cycle in which that final 1 is presented, before the edge that samples it.
- R5: After a flagged match the detector returns to idle. The stream 1,0,1,0,1 flags exactly once, on the third bit, and flags again only after a new 1,0,1 has arrived.
- R6: In the seen-1-then-0 state, a 0 returns the detector to idle without flagging. The stream 1,0,0,1 does not flag on its fourth bit.
- R7: For any input stream that starts after reset, `hit` is 1 exactly at the positions where a left-to-right scan finds a 1,0,1 window that shares no bit with the previously flagged window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, stable around each rising edge |
| hit | output | 1 | Mealy detect flag, high while a completed 1,0,1 is being presented |

## Verification
The case hardest to reach from the ports is the no-overlap rule. The trailing 1 of a match would start a new pattern in an overlapping detector, and here it must not. Seeing this requires a stream in which a 1,0,1 window shares its first bit with the end of the previous match. The bench sweeps every 8-bit stream from reset and compares each cycle of `hit` with a window scan that skips overlapping windows. This covers every such overlap, and also the 1,1 and 1,0,0 recovery paths. Directed streams add the 1,0,1,0,1 case and a reset applied in the middle of a partial pattern.

// File: rtl/pat101_pkg.sv
package pat101_pkg;
  localparam int ST_W = 2;

  // Fixed codes: idle 00, seen-1 01, seen-1-0 10, 11 unused.
  typedef enum logic [ST_W-1:0] {
    ST_IDLE    = 2'b00,
    ST_ONE     = 2'b01,
    ST_ONEZERO = 2'b10,
    ST_SPARE   = 2'b11
  } det_st_t;
endpackage

// File: rtl/pat101_next.sv
module pat101_next
  import pat101_pkg::*;
(
  input  det_st_t cur,
  input  logic    bit_i,
  output det_st_t nxt
);
  always_comb begin
    unique case (cur)
      ST_IDLE:    nxt = bit_i ? ST_ONE  : ST_IDLE;
      ST_ONE:     nxt = bit_i ? ST_ONE  : ST_ONEZERO;
      // a completed match or a broken pattern both restart from idle
      ST_ONEZERO: nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pat101_out.sv
module pat101_out
  import pat101_pkg::*;
(
  input  det_st_t cur,
  input  logic    bit_i,
  output logic    hit_o
);
  always_comb begin
    unique case (cur)
      ST_ONEZERO: hit_o = bit_i;
      default:    hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pat101_sreg.sv
module pat101_sreg
  import pat101_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  det_st_t nxt,
  output det_st_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= ST_IDLE;
    else     cur <= nxt;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> cur == ST_IDLE);

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (rst) cur != ST_SPARE);
endmodule

// File: rtl/pat101_detect.sv
module pat101_detect
  import pat101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  det_st_t cur;
  det_st_t nxt;

  pat101_sreg u_sreg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  pat101_next u_next (
    .cur   (cur),
    .bit_i (din),
    .nxt   (nxt)
  );

  pat101_out u_out (
    .cur   (cur),
    .bit_i (din),
    .hit_o (hit)
  );

  // R4
  hit_needs_one_chk: assert property (@(posedge clk) disable iff (rst) hit |-> din);

  // R5
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst) hit |=> !hit);

  // R5
  hit_then_idle_chk: assert property (@(posedge clk) disable iff (rst) hit |=> cur == ST_IDLE);

  // R2
  onezero_entry_chk: assert property (@(posedge clk) disable iff (rst)
    cur == ST_ONEZERO |-> ($past(cur) == ST_ONE && !$past(din)));
endmodule

// File: tb/test_pat101_detect.sv
module test_pat101_detect;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int n_chk  = 0;
  int n_fail = 0;

  pat101_detect i_pat101_detect (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit)
  );

  always #5 clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: hit=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Hold reset for one edge, check the flag during it, release.
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    #2;
    check(hit, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Present n bits (bit 0 first), one per cycle, after a reset.
  // Expected flag: leftmost non-overlapping 1,0,1 scan.
  task automatic run_seq(input logic [15:0] bits, input int n, input string tag_ovl);
    int last_end = -10;
    do_reset();
    for (int i = 0; i < n; i++) begin
      logic win;
      logic exp;
      string tag;
      if (i != 0) @(negedge clk);
      din = bits[i];
      win = (i >= 2) && bits[i] && !bits[i-1] && bits[i-2];
      exp = win && (i - 2 > last_end);
      if (exp) last_end = i;
      if (exp)      tag = "R4";
      else if (win) tag = tag_ovl;
      else          tag = "R7";
      #2;
      check(hit, exp, tag);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: expired, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);

    // R5: 1,0,1,0,1 flags once; then 0,1 completes a fresh match at bit 6
    run_seq(16'b000000_1010_10101, 7, "R5");

    // R3: 1,1,0,1 flags on fourth bit
    do_reset();
    din = 1'b1; #2; check(hit, 1'b0, "R3");
    @(negedge clk); din = 1'b1; #2; check(hit, 1'b0, "R3");
    @(negedge clk); din = 1'b0; #2; check(hit, 1'b0, "R3");
    @(negedge clk); din = 1'b1; #2; check(hit, 1'b1, "R3");

    // R6: 1,0,0,1 no flag on fourth; then 0,1 flags
    do_reset();
    din = 1'b1; #2; check(hit, 1'b0, "R6");
    @(negedge clk); din = 1'b0; #2; check(hit, 1'b0, "R6");
    @(negedge clk); din = 1'b0; #2; check(hit, 1'b0, "R6");
    @(negedge clk); din = 1'b1; #2; check(hit, 1'b0, "R6");
    @(negedge clk); din = 1'b0; #2; check(hit, 1'b0, "R6");
    @(negedge clk); din = 1'b1; #2; check(hit, 1'b1, "R6");

    // R2: idle holds on 0s, flag stays low with 1 present in idle
    do_reset();
    din = 1'b0; #2; check(hit, 1'b0, "R2");
    @(negedge clk); din = 1'b0; #2; check(hit, 1'b0, "R2");
    @(negedge clk); din = 1'b1; #2; check(hit, 1'b0, "R2");

    // R1: reset in the middle of 1,0 discards the partial pattern
    do_reset();
    din = 1'b1; #2; check(hit, 1'b0, "R1");
    @(negedge clk); din = 1'b0; #2; check(hit, 1'b0, "R1");
    @(negedge clk); rst = 1'b1; din = 1'b0; #2; check(hit, 1'b0, "R1");
    @(negedge clk); rst = 1'b0; din = 1'b1; #2; check(hit, 1'b0, "R1");
    @(negedge clk); din = 1'b0; #2; check(hit, 1'b0, "R1");
    @(negedge clk); din = 1'b1; #2; check(hit, 1'b1, "R1");

    // R7: every 8-bit stream from reset against the window scan
    for (int s = 0; s < 256; s++) begin
      run_seq(16'(s), 8, "R5");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule